// File: doc/BRIEF.md
# Row-Decaying Hybrid Branch Predictor

This block predicts the direction of conditional branches with a tournament of two direction tables: a bimodal table addressed by the branch address and a history-hashed table addressed by the branch address XOR a global history register. A third table of 2-bit counters chooses between them. Each table is laid out as a square array of rows, and each row is switched off to save leakage once it has gone unused for a programmable interval. An inactive row has lost its counters. When the next access reaches that row, the row comes back with every counter at weakly-not-taken.

The front end sends a prediction request carrying the branch address on a valid/ready stream. The answer arrives one cycle later on a response stream with valid/ready, and it comes with the history value that was used. The requester must keep that history and return it with the branch outcome on the update stream. The update stream is always ready and takes one resolved branch in every cycle in which its valid is high. A predict request is accepted only when `pred_ready` is high, and `pred_ready` is high exactly when the response register is empty or is being drained in the same cycle. While `resp_ready` is low, a held response stays unchanged. Per-row activity vectors for each table are exported for observation.

Top module: `row_decay_predictor`

## Requirements
- R1: After reset every row of every table is inactive, `resp_valid` is 0 and the global history is zero.
- R2: Direction entries are 2-bit saturating counters that predict taken when bit 1 is set. Every update moves both the bimodal entry and the hashed entry one step toward the actual outcome, saturating at 0 and 3.
- R3: The table index is `pc[PC_LSB +: IDX_W]`. The bimodal and chooser tables use it directly. The hashed table uses it XOR the history: the live history for a predict, and `upd_hist` for an update.
- R4: The chooser entry moves one step toward the hashed component (up) or toward the bimodal component (down) only when exactly one of the two component counters, read at update time, matched the outcome. A chooser value with bit 1 set prefers the hashed component.
- R5: An inactive row predicts not-taken. If the preferred component's row is inactive and the other component's row is active, the active component's prediction is used. If both component rows are inactive, the bimodal (not-taken) result is used.
- R6: A prescaler ticks once every `decay_interval`+1 cycles. Each active row that is not accessed on a tick advances its 2-bit idle count, and the row goes inactive on the third such tick. An access clears the idle count.
- R7: Any predict or update access to an inactive row reactivates it and loads all entries of that row with 01. An update then trains its own entry starting from 01.
- R8: Each update shifts its outcome into the LSB of the global history. A predict accepted in the same cycle as an update sees the tables and the history as they are after that update, and returns that history in `resp_hist`.
- R9: A request accepted at a clock edge yields `resp_valid`=1 with its result after that edge. The response holds, unchanged, while `resp_ready` is low. `pred_ready` = !`resp_valid` || `resp_ready`.
- R10: `upd_ready` is always 1, and every cycle with `upd_valid` high performs one update.
- R11: Row r of a table holds indices whose upper `ROW_W` index bits equal r. Bit r of that table's activity output reports whether the row is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decay_interval | input | PRESC_W | Decay tick period minus one, in cycles |
| pred_valid | input | 1 | Predict request valid |
| pred_ready | output | 1 | Predict request accepted when high |
| pred_pc | input | PC_W | Branch address to predict |
| resp_valid | output | 1 | Prediction response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_taken | output | 1 | Predicted direction |
| resp_hist | output | IDX_W | Global history used by the prediction |
| upd_valid | input | 1 | Resolved branch valid |
| upd_ready | output | 1 | Always high |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_hist | input | IDX_W | History snapshot returned from the response |
| bim_row_active | output | ROWS | Per-row active flags, bimodal table |
| gsh_row_active | output | ROWS | Per-row active flags, hashed table |
| cho_row_active | output | ROWS | Per-row active flags, chooser table |

## Verification
A predict result becomes visible one clock edge after the request is accepted. Any update at that same edge is already reflected in it, so the reference model applies the update before the predict within each modelled edge. Row activity, counter training and history changes all take effect at the edge where the access or the decay tick occurs. The bench therefore drives inputs on the falling edge and compares every output with the model on the next falling edge, one rising edge later. Directed sequences pin down training to taken, decay under a one-cycle tick, the not-taken default and the reload on wake-up. Phases with varied tick periods and traffic densities then compare all outputs on every cycle.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t WEAK_NT = 2'b01;

  // saturating step of a 2-bit counter toward up (1) or down (0)
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t n;
    if (up) n = (c == 2'b11) ? c : c + 2'b01;
    else    n = (c == 2'b00) ? c : c - 2'b01;
    return n;
  endfunction
endpackage

// File: rtl/rdp_prescaler.sv
module rdp_prescaler #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_m1,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  // comparison with >= so that a shrinking period never wraps the counter
  assign tick = (cnt_q >= period_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rdp_row_decay.sv
module rdp_row_decay (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic touch,
  output logic active,
  output logic woken
);
  logic [1:0] idle_q;
  logic       act_q;

  assign active = act_q;
  assign woken  = touch & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 2'b11;
      act_q  <= 1'b0;
    end else if (touch) begin
      idle_q <= 2'b00;
      act_q  <= 1'b1;
    end else if (tick && act_q) begin
      idle_q <= idle_q + 2'b01;
      if (idle_q == 2'b10) act_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rdp_table.sv
module rdp_table
  import rdp_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int ROW_W = (IDX_W + 1) / 2,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             upd_access,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_write,
  input  logic             upd_up,
  output ctr2_t            upd_cur,
  input  logic             pred_access,
  input  logic [IDX_W-1:0] pred_idx,
  output ctr2_t            pred_ctr,
  output logic             pred_act,
  output logic [ROWS-1:0]  row_act
);
  localparam int COL_W   = IDX_W - ROW_W;
  localparam int ENTRIES = 1 << IDX_W;

  ctr2_t            mem [ENTRIES];
  logic [ROWS-1:0]  touch;
  logic [ROWS-1:0]  woken;
  logic [ROW_W-1:0] urow;
  logic [ROW_W-1:0] prow;
  ctr2_t            upd_new;
  ctr2_t            pred_base;

  assign urow = upd_idx[IDX_W-1 -: ROW_W];
  assign prow = pred_idx[IDX_W-1 -: ROW_W];

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      touch[r] = (upd_access && urow == ROW_W'(r)) ||
                 (pred_access && prow == ROW_W'(r));
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    rdp_row_decay u_decay (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .touch  (touch[r]),
      .active (row_act[r]),
      .woken  (woken[r])
    );
  end

  // value seen by the update: a dead row reads as freshly reloaded
  assign upd_cur = row_act[urow] ? mem[upd_idx] : WEAK_NT;
  assign upd_new = ctr_step(upd_cur, upd_up);

  // predict read forwards the same-edge update
  assign pred_base = row_act[prow] ? mem[pred_idx] : WEAK_NT;
  assign pred_act  = row_act[prow] | (upd_access && urow == prow);
  assign pred_ctr  = (upd_write && upd_idx == pred_idx) ? upd_new : pred_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= WEAK_NT;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (woken[e >> COL_W]) mem[e] <= WEAK_NT;
        if (upd_write && upd_idx == IDX_W'(e)) mem[e] <= upd_new;
      end
    end
  end
endmodule

// File: rtl/rdp_select.sv
module rdp_select (
  input  logic bim_act,
  input  logic bim_dir,
  input  logic gsh_act,
  input  logic gsh_dir,
  input  logic pref_gsh,
  output logic taken
);
  logic use_gsh;

  assign use_gsh = gsh_act & (pref_gsh | ~bim_act);
  assign taken   = use_gsh ? gsh_dir : (bim_act & bim_dir);
endmodule

// File: rtl/row_decay_predictor.sv
module row_decay_predictor
  import rdp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 6,
  parameter int PC_LSB  = 2,
  parameter int PRESC_W = 12,
  localparam int ROW_W  = (IDX_W + 1) / 2,
  localparam int ROWS   = 1 << ROW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] decay_interval,
  input  logic               pred_valid,
  output logic               pred_ready,
  input  logic [PC_W-1:0]    pred_pc,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_taken,
  output logic [IDX_W-1:0]   resp_hist,
  input  logic               upd_valid,
  output logic               upd_ready,
  input  logic [PC_W-1:0]    upd_pc,
  input  logic               upd_taken,
  input  logic [IDX_W-1:0]   upd_hist,
  output logic [ROWS-1:0]    bim_row_active,
  output logic [ROWS-1:0]    gsh_row_active,
  output logic [ROWS-1:0]    cho_row_active
);
  logic             dec_tick;
  logic             pred_fire;
  logic             upd_fire;
  logic [IDX_W-1:0] ghr_q;
  logic [IDX_W-1:0] ghr_eff;
  logic [IDX_W-1:0] p_idx, u_idx, p_gidx, u_gidx;
  ctr2_t            b_ucur, g_ucur, c_ucur;
  ctr2_t            b_pctr, g_pctr, c_pctr;
  logic             b_pact, g_pact, c_pact;
  logic             b_ok, g_ok;
  logic             pick_taken;
  logic             resp_v_q, resp_t_q;
  logic [IDX_W-1:0] resp_h_q;

  assign upd_ready  = 1'b1;
  assign upd_fire   = upd_valid;
  assign pred_ready = ~resp_v_q | resp_ready;
  assign pred_fire  = pred_valid & pred_ready;

  assign p_idx  = pred_pc[PC_LSB +: IDX_W];
  assign u_idx  = upd_pc[PC_LSB +: IDX_W];
  assign ghr_eff = upd_fire ? {ghr_q[IDX_W-2:0], upd_taken} : ghr_q;
  assign p_gidx = p_idx ^ ghr_eff;
  assign u_gidx = u_idx ^ upd_hist;

  wire unused_bits = ^{pred_pc, upd_pc, b_ucur[0], g_ucur[0], c_ucur,
                       b_pctr[0], g_pctr[0], c_pctr[0], c_pact};

  rdp_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .period_m1 (decay_interval),
    .tick      (dec_tick)
  );

  assign b_ok = (b_ucur[1] == upd_taken);
  assign g_ok = (g_ucur[1] == upd_taken);

  rdp_table #(.IDX_W(IDX_W)) u_bim (
    .clk (clk), .rst_n (rst_n), .tick (dec_tick),
    .upd_access (upd_fire), .upd_idx (u_idx), .upd_write (upd_fire),
    .upd_up (upd_taken), .upd_cur (b_ucur),
    .pred_access (pred_fire), .pred_idx (p_idx),
    .pred_ctr (b_pctr), .pred_act (b_pact), .row_act (bim_row_active)
  );

  rdp_table #(.IDX_W(IDX_W)) u_gsh (
    .clk (clk), .rst_n (rst_n), .tick (dec_tick),
    .upd_access (upd_fire), .upd_idx (u_gidx), .upd_write (upd_fire),
    .upd_up (upd_taken), .upd_cur (g_ucur),
    .pred_access (pred_fire), .pred_idx (p_gidx),
    .pred_ctr (g_pctr), .pred_act (g_pact), .row_act (gsh_row_active)
  );

  rdp_table #(.IDX_W(IDX_W)) u_cho (
    .clk (clk), .rst_n (rst_n), .tick (dec_tick),
    .upd_access (upd_fire), .upd_idx (u_idx),
    .upd_write (upd_fire & (b_ok ^ g_ok)),
    .upd_up (g_ok), .upd_cur (c_ucur),
    .pred_access (pred_fire), .pred_idx (p_idx),
    .pred_ctr (c_pctr), .pred_act (c_pact), .row_act (cho_row_active)
  );

  rdp_select u_sel (
    .bim_act  (b_pact),
    .bim_dir  (b_pctr[1]),
    .gsh_act  (g_pact),
    .gsh_dir  (g_pctr[1]),
    .pref_gsh (c_pctr[1]),
    .taken    (pick_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr_q <= '0;
    else if (upd_fire) ghr_q <= ghr_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_v_q <= 1'b0;
      resp_t_q <= 1'b0;
      resp_h_q <= '0;
    end else if (pred_fire) begin
      resp_v_q <= 1'b1;
      resp_t_q <= pick_taken;
      resp_h_q <= ghr_eff;
    end else if (resp_ready) begin
      resp_v_q <= 1'b0;
    end
  end

  assign resp_valid = resp_v_q;
  assign resp_taken = resp_t_q;
  assign resp_hist  = resp_h_q;
endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
  parameter int IDX_W = 6,
  parameter int ROWS  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pred_valid,
  input logic             pred_ready,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic             resp_taken,
  input logic [IDX_W-1:0] resp_hist,
  input logic             upd_valid,
  input logic             upd_taken,
  input logic [ROWS-1:0]  bim_row_active,
  input logic [ROWS-1:0]  cho_row_active,
  input logic [IDX_W-1:0] ghr,
  input logic             tick
);
  assert_resp_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready) |=> resp_valid);

  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_taken) && $stable(resp_hist)));

  assert_ghr_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghr == {$past(ghr[IDX_W-2:0]), $past(upd_taken)}));

  assert_ghr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghr));

  // R6: a row may only switch off on a decay tick
  assert_bim_off_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(bim_row_active) & ~bim_row_active)) |-> $past(tick));

  assert_cho_off_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(cho_row_active) & ~cho_row_active)) |-> $past(tick));

  // R7: a row only comes back through an access
  assert_bim_wake_on_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bim_row_active & ~$past(bim_row_active))) |->
      $past(upd_valid || (pred_valid && pred_ready)));
endmodule

bind row_decay_predictor rdp_checker #(.IDX_W(IDX_W), .ROWS(ROWS)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pred_valid     (pred_valid),
  .pred_ready     (pred_ready),
  .resp_valid     (resp_valid),
  .resp_ready     (resp_ready),
  .resp_taken     (resp_taken),
  .resp_hist      (resp_hist),
  .upd_valid      (upd_valid),
  .upd_taken      (upd_taken),
  .bim_row_active (bim_row_active),
  .cho_row_active (cho_row_active),
  .ghr            (ghr_q),
  .tick           (dec_tick)
);

// File: tb/row_decay_predictor_tb.sv
`timescale 1ns/1ps
module row_decay_predictor_tb;
  localparam int PC_W = 32, IDX_W = 6, PRESC_W = 12, ROWS = 8, ENT = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [PRESC_W-1:0] decay_interval;
  logic               pred_valid, pred_ready, resp_valid, resp_ready, resp_taken;
  logic [PC_W-1:0]    pred_pc, upd_pc;
  logic [IDX_W-1:0]   resp_hist, upd_hist;
  logic               upd_valid, upd_ready, upd_taken;
  logic [ROWS-1:0]    bim_row_active, gsh_row_active, cho_row_active;

  row_decay_predictor u_dut (
    .clk (clk), .rst_n (rst_n), .decay_interval (decay_interval),
    .pred_valid (pred_valid), .pred_ready (pred_ready), .pred_pc (pred_pc),
    .resp_valid (resp_valid), .resp_ready (resp_ready), .resp_taken (resp_taken),
    .resp_hist (resp_hist), .upd_valid (upd_valid), .upd_ready (upd_ready),
    .upd_pc (upd_pc), .upd_taken (upd_taken), .upd_hist (upd_hist),
    .bim_row_active (bim_row_active), .gsh_row_active (gsh_row_active),
    .cho_row_active (cho_row_active)
  );

  int n_checks = 0;
  int n_err    = 0;

  // ---------------- reference model ----------------
  int ctr  [3][ENT];
  bit act  [3][ROWS];
  int idle [3][ROWS];
  bit hit  [3][ROWS];
  int m_presc, m_ghr, m_rh;
  bit m_rv, m_rt;

  function automatic int cur(int t, int i);
    return act[t][i / 8] ? ctr[t][i] : 1;
  endfunction

  function automatic int sat(int v, bit up);
    if (up) return (v == 3) ? 3 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic wake(int t, int i);
    int r = i / 8;
    hit[t][r] = 1'b1;
    if (!act[t][r]) begin
      for (int c = 0; c < 8; c++) ctr[t][r * 8 + c] = 1;
      act[t][r] = 1'b1;
    end
    idle[t][r] = 0;
  endtask

  task automatic model_reset();
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < ENT; i++) ctr[t][i] = 1;
      for (int r = 0; r < ROWS; r++) begin act[t][r] = 0; idle[t][r] = 3; end
    end
    m_presc = 0; m_ghr = 0; m_rv = 0; m_rt = 0; m_rh = 0;
  endtask

  task automatic model_step();
    bit tick, pfire;
    tick = (m_presc >= int'(decay_interval));
    m_presc = tick ? 0 : m_presc + 1;
    for (int t = 0; t < 3; t++) for (int r = 0; r < ROWS; r++) hit[t][r] = 0;
    pfire = pred_valid && (!m_rv || resp_ready);
    if (upd_valid) begin
      int bi, gi, bv, gv, cv;
      bit bok, gok;
      bi = int'(upd_pc >> 2) % 64;
      gi = bi ^ int'(upd_hist);
      bv = cur(0, bi); gv = cur(1, gi); cv = cur(2, bi);
      bok = ((bv >= 2) == upd_taken);
      gok = ((gv >= 2) == upd_taken);
      wake(0, bi); ctr[0][bi] = sat(bv, upd_taken);
      wake(1, gi); ctr[1][gi] = sat(gv, upd_taken);
      wake(2, bi); if (bok != gok) ctr[2][bi] = sat(cv, gok);
      m_ghr = ((m_ghr << 1) | int'(upd_taken)) % 64;
    end
    if (pfire) begin
      int pi, pg;
      bit ba, ga, bt, gt, pref, useg;
      pi = int'(pred_pc >> 2) % 64;
      pg = pi ^ m_ghr;
      ba = act[0][pi / 8]; ga = act[1][pg / 8];
      bt = ba && (cur(0, pi) >= 2);
      gt = ga && (cur(1, pg) >= 2);
      pref = (cur(2, pi) >= 2);
      useg = (pref && ga) || (!ba && ga);
      m_rt = useg ? gt : bt;
      m_rh = m_ghr;
      m_rv = 1;
      wake(0, pi); wake(1, pg); wake(2, pi);
    end else if (resp_ready) begin
      m_rv = 0;
    end
    for (int t = 0; t < 3; t++)
      for (int r = 0; r < ROWS; r++)
        if (!hit[t][r] && tick && act[t][r]) begin
          idle[t][r]++;
          if (idle[t][r] == 3) act[t][r] = 0;
        end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  function automatic logic [7:0] rows_of(int t);
    logic [7:0] v;
    for (int r = 0; r < ROWS; r++) v[r] = act[t][r];
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(32'(resp_valid), 32'(m_rv), "R9 resp_valid");
    chk(32'(pred_ready), 32'(!m_rv || resp_ready), "R9 pred_ready");
    chk(32'(upd_ready), 32'd1, "R10 upd_ready");
    if (m_rv) begin
      chk(32'(resp_taken), 32'(m_rt), "R2,R3,R4,R5 resp_taken");
      chk(32'(resp_hist), 32'(m_rh), "R8 resp_hist");
    end
    chk(32'(bim_row_active), 32'(rows_of(0)), "R6,R11 bim rows");
    chk(32'(gsh_row_active), 32'(rows_of(1)), "R6,R7 gsh rows");
    chk(32'(cho_row_active), 32'(rows_of(2)), "R6,R11 cho rows");
  endtask

  task automatic cyc();
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  int pc_set [16];
  int bias   [16];
  int ivals  [8] = '{0, 1, 3, 7, 2, 0, 5, 1};

  initial begin
    rst_n = 0; decay_interval = 12'd1000;
    pred_valid = 0; pred_pc = '0; resp_ready = 1;
    upd_valid = 0; upd_pc = '0; upd_taken = 0; upd_hist = '0;
    for (int j = 0; j < 16; j++) begin
      pc_set[j] = int'($urandom_range(0, 63)) * 4;
      bias[j]   = (j % 4 == 0) ? 5 : ((j % 2 == 0) ? 9 : 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk(32'(resp_valid), 0, "R1 resp_valid");
    chk(32'(bim_row_active), 0, "R1 bim rows");
    chk(32'(gsh_row_active | cho_row_active), 0, "R1 other rows");

    // R2: train idx 5 taken twice, then predict it
    upd_valid = 1; upd_pc = 32'd20; upd_taken = 1; upd_hist = '0;
    cyc();
    cyc();
    upd_valid = 0; pred_valid = 1; pred_pc = 32'd20;
    cyc();
    chk(32'(resp_taken), 1, "R2 trained taken");
    chk(32'(resp_hist), 32'd3, "R8 history after two taken");

    // R6: one-cycle ticks, three idle edges switch every row off
    pred_valid = 0; decay_interval = '0;
    cyc(); cyc(); cyc();
    chk(32'(bim_row_active), 0, "R6 bim rows off");

    // R5 / R7: inactive row predicts not-taken, wake reloads weakly-not-taken
    pred_valid = 1;
    cyc();
    chk(32'(resp_taken), 0, "R5 inactive default");
    chk(32'(bim_row_active[0]), 1, "R7 row woken");
    decay_interval = 12'd1000;
    cyc();
    chk(32'(resp_taken), 0, "R7 reloaded counter");
    pred_valid = 0;
    cyc();

    // mixed traffic phases
    for (int p = 0; p < 8; p++) begin
      decay_interval = PRESC_W'(ivals[p]);
      for (int k = 0; k < 600; k++) begin
        int busy = (p % 2 == 1) ? 90 : 15;
        int jp   = int'($urandom_range(0, 15));
        int ju   = int'($urandom_range(0, 15));
        pred_valid = ($urandom_range(0, 99) < busy);
        pred_pc    = PC_W'(pc_set[jp]);
        resp_ready = ($urandom_range(0, 9) != 0);
        upd_valid  = ($urandom_range(0, 99) < busy);
        upd_pc     = PC_W'(pc_set[ju]);
        upd_taken  = (int'($urandom_range(0, 9)) < bias[ju]);
        upd_hist   = (ju % 2 == 0) ? IDX_W'(m_rh) : IDX_W'($urandom_range(0, 63));
        cyc();
      end
    end
    pred_valid = 0; upd_valid = 0; resp_ready = 1;
    cyc(); cyc();
    finish_run();
  end
endmodule